// File: doc/BRIEF.md
# Six-Channel Pulse Generator with Lead-In and Repeat Count

This block drives six independent pulse-width modulated outputs from a single clock. Software sets up each channel with two 32-bit words. The timing word holds a high interval and a low interval, both counted in clock cycles. The control word holds an enable flag, a lead-in interval and a repeat count. Once enabled, a channel first holds its pin low for the lead-in interval. It then produces periods of `high + low` cycles, with the pin high at the start of each period.

A repeat count of zero keeps the waveform running until software clears the enable flag. A nonzero count stops the channel after exactly that many periods. When it stops, the channel drops its pin and clears its own enable flag. Timing changes made while a channel runs are picked up only at the next period boundary. Clearing the enable flag silences the pin at once.

The register port is plain and synchronous. Writes take effect on the clock edge on which `reg_wr` is sampled. Read data is a combinational function of `reg_addr`.

Top module: `pwmx_top`

## Requirements
- R1: After reset every pin is low and every mapped word reads zero.
- R2: Channel c's control word is at byte address 4*c, with enable in bit 31, lead-in in bits 30:16 and repeat count in bits 15:0. Its timing word is at 0x20 + 4*c, with high time in bits 31:16 and low time in bits 15:0. A written word reads back unchanged on the next cycle.
- R3: While running, each period lasts H+L cycles, and the pin is high for the first H of them.
- R4: If enable is written at clock edge E with lead-in N, the pin stays low in the N+1 cycles after E and is first high after edge E+N+1, provided H>0.
- R5: A repeat count of zero keeps the waveform going without end.
- R6: A repeat count R>0 gives exactly R periods. After the last period the pin stays low and the enable bit reads 0.
- R7: Writing a control word with bit 31 clear drives that channel's pin low in the cycle right after the write edge.
- R8: A timing write during a period leaves that period unchanged. The new values apply from the following period.
- R9: With H=0 the pin stays low. With L=0 and H>0 the pin stays high after the lead-in.
- R10: Byte addresses 0x18, 0x1C, 0x38 and 0x3C read zero, and writes to them change no word and no pin.
- R11: Each channel's waveform depends only on its own two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Byte address (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pwm_out | output | N_CH | One pulse output per channel |

## Verification
A phase counter that drifts by one shows up as a period that is one cycle too long or too short. It becomes visible within the first period after enable. A repeat counter that is off by one adds or drops a whole period at the end, and it also changes when the enable bit reads back as zero. An active-timing latch taken at the wrong moment shows up as a period whose shape is neither the old one nor the new one, right after a timing write. Every trace is compared cycle by cycle against a waveform computed from the programmed H, L, N and R.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    localparam int CNT_W  = 16;
    localparam int LEAD_W = 15;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    typedef struct packed {
        logic              en;
        logic [LEAD_W-1:0] lead;
        logic [CNT_W-1:0]  reps;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } tmg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_RUN} chst_e;

    typedef struct packed {
        logic       is_tmg;
        logic [2:0] idx;
    } regsel_t;

    function automatic regsel_t decode(input logic [ADDR_W-1:0] a);
        regsel_t r;
        r.is_tmg = a[5];
        r.idx    = a[4:2];
        return r;
    endfunction
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [N_CH-1:0]          fin,
    output logic [DATA_W-1:0]        rdata,
    output ctrl_t [N_CH-1:0]         ctrl_o,
    output tmg_t  [N_CH-1:0]         tmg_o
);
    regsel_t sel;
    assign sel = decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            tmg_o  <= '0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (wr && !sel.is_tmg && sel.idx == 3'(c))
                    ctrl_o[c] <= ctrl_t'(wdata);
                else if (fin[c])
                    ctrl_o[c].en <= 1'b0;   // software write takes priority
                if (wr && sel.is_tmg && sel.idx == 3'(c))
                    tmg_o[c] <= tmg_t'(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (sel.idx == 3'(c))
                rdata = sel.is_tmg ? DATA_W'(tmg_o[c]) : DATA_W'(ctrl_o[c]);
        end
    end
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t cfg,
    input  tmg_t  tmg,
    output logic  pwm,
    output logic  fin
);
    chst_e             st;
    logic [LEAD_W-1:0] lcnt;
    logic [CNT_W:0]    pos;
    tmg_t              act;
    logic [CNT_W-1:0]  done_n;

    logic [CNT_W:0] plen;
    logic           last, last_rep;

    assign plen     = {1'b0, act.hi} + {1'b0, act.lo};
    assign last     = (plen == '0) || (pos == plen - 17'd1);
    assign last_rep = (cfg.reps != '0) && ({1'b0, done_n} + 17'd1 == {1'b0, cfg.reps});
    assign fin      = cfg.en && (st == ST_RUN) && last && last_rep;
    assign pwm      = cfg.en && (st == ST_RUN) && (pos < {1'b0, act.hi});

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            lcnt   <= '0;
            pos    <= '0;
            act    <= '0;
            done_n <= '0;
        end else if (!cfg.en) begin
            st     <= ST_IDLE;
            pos    <= '0;
            done_n <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    pos    <= '0;
                    done_n <= '0;
                    act    <= tmg;
                    if (cfg.lead == '0) begin
                        st <= ST_RUN;
                    end else begin
                        st   <= ST_LEAD;
                        lcnt <= cfg.lead;
                    end
                end
                ST_LEAD: begin
                    if (lcnt == LEAD_W'(1)) begin
                        st  <= ST_RUN;
                        act <= tmg;
                        pos <= '0;
                    end else begin
                        lcnt <= lcnt - LEAD_W'(1);
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        if (last_rep) begin
                            st <= ST_IDLE;
                        end else begin
                            pos    <= '0;
                            act    <= tmg;          // new timing at boundary
                            done_n <= done_n + CNT_W'(1);
                        end
                    end else begin
                        pos <= pos + 17'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
    import pwmx_pkg::*;
#(
    parameter int N_CH = 6   // at most 8: address decode has three index bits
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [N_CH-1:0]   pwm_out
);
    ctrl_t [N_CH-1:0] ctrl;
    tmg_t  [N_CH-1:0] tmg;
    logic  [N_CH-1:0] fin;
    logic  [N_CH-1:0] ch_en;

    pwmx_regs #(.N_CH(N_CH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .fin    (fin),
        .rdata  (reg_rdata),
        .ctrl_o (ctrl),
        .tmg_o  (tmg)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwmx_chan u_ch (
            .clk (clk),
            .rst (rst),
            .cfg (ctrl[c]),
            .tmg (tmg[c]),
            .pwm (pwm_out[c]),
            .fin (fin[c])
        );
        assign ch_en[c] = ctrl[c].en;
    end
endmodule

// File: rtl/pwmx_chk.sv
module pwmx_chk #(
    parameter int N_CH = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic [5:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [31:0]     reg_rdata,
    input logic [N_CH-1:0] pwm_out,
    input logic [N_CH-1:0] ch_en
);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(reg_addr[4:2]) >= N_CH) |-> (reg_rdata == '0));

    // R2
    tmg_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[5] && 32'(reg_addr[4:2]) < N_CH)
        |=> (!$stable(reg_addr) || reg_rdata == $past(reg_wdata)));

    for (genvar c = 0; c < N_CH; c++) begin : g_c
        // R7
        off_now_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == 6'(4 * c) && !reg_wdata[31]) |=> !pwm_out[c]);

        // R4
        rise_after_en_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_out[c]) |-> $past(ch_en[c]));

        // R6
        hw_stop_low_chk: assert property (@(posedge clk) disable iff (rst)
            ($fell(ch_en[c]) && !$past(reg_wr)) |-> !pwm_out[c]);
    end
endmodule

bind pwmx_top pwmx_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en)
);

// File: tb/pwmx_top_tb.sv
module pwmx_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [5:0]  pwm;
    logic [5:0]  tr [0:63];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwmx_top #(.N_CH(6)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm)
    );

    function automatic bit exp_bit(int k, int n, int h, int l, int r);
        int j, p;
        if (k <= n) return 1'b0;
        j = k - n - 1;
        p = h + l;
        if (p == 0) return 1'b0;
        if (r != 0 && j >= r * p) return 1'b0;
        return (j % p) < h;
    endfunction

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
        end
    endtask

    task automatic pin_chk(input int ch, input logic e, input string tag);
        checks++;
        if (pwm[ch] !== e) begin
            fails++;
            $display("FAIL %s ch%0d actual=%b expected=%b", tag, ch, pwm[ch], e);
        end
    endtask

    task automatic grab(input int n);
        for (int i = 0; i < n; i++) begin
            tr[i] = pwm;
            @(negedge clk);
        end
    endtask

    task automatic cmp(input int ch, input int off, input int n, input int ln,
                       input int h, input int l, input int r, input string tag);
        bit bad = 1'b0;
        checks++;
        for (int i = 0; i < n; i++) begin
            if (!bad && tr[i][ch] !== exp_bit(i + off, ln, h, l, r)) begin
                bad = 1'b1;
                fails++;
                $display("FAIL %s ch%0d sample %0d actual=%b expected=%b",
                         tag, ch, i + off, tr[i][ch], exp_bit(i + off, ln, h, l, r));
            end
        end
    endtask

    task automatic all_off();
        for (int c = 0; c < 6; c++) wr_reg(6'(4 * c), 32'h0);
    endtask

    task automatic t_reset();
        for (int c = 0; c < 6; c++) begin
            rd_chk(6'(4 * c), 32'h0, "R1 ctrl");
            rd_chk(6'(6'h20 + 4 * c), 32'h0, "R1 timing");
        end
        checks++;
        if (pwm !== 6'h0) begin
            fails++;
            $display("FAIL R1 pins actual=%h expected=00", pwm);
        end
    endtask

    task automatic t_readback();
        wr_reg(6'h24, 32'h1234_5678);
        rd_chk(6'h24, 32'h1234_5678, "R2 timing");
        wr_reg(6'h04, 32'h0005_0003);
        rd_chk(6'h04, 32'h0005_0003, "R2 ctrl");
        wr_reg(6'h14, 32'hFFFF_0000);
        rd_chk(6'h14, 32'hFFFF_0000, "R2 ctrl en");
        pin_chk(5, 1'b0, "R4 long lead");
        all_off();
    endtask

    task automatic t_basic();
        wr_reg(6'h20, 32'h0003_0002);
        wr_reg(6'h00, 32'h8000_0000);
        grab(40);
        cmp(0, 0, 40, 0, 3, 2, 0, "R3 R5 basic");
        all_off();
    endtask

    task automatic t_lead();
        wr_reg(6'h28, 32'h0002_0003);
        wr_reg(6'h08, 32'h8004_0000);
        grab(25);
        cmp(2, 0, 25, 4, 2, 3, 0, "R4 lead");
        all_off();
    endtask

    task automatic t_repeat();
        wr_reg(6'h2C, 32'h0002_0001);
        wr_reg(6'h0C, 32'h8001_0003);
        grab(20);
        cmp(3, 0, 20, 1, 2, 1, 3, "R6 repeat");
        rd_chk(6'h0C, 32'h0001_0003, "R6 enable cleared");
        all_off();
    endtask

    task automatic t_disable();
        wr_reg(6'h20, 32'h0005_0005);
        wr_reg(6'h00, 32'h8000_0000);
        @(negedge clk);
        @(negedge clk);
        pin_chk(0, 1'b1, "R3 mid high");
        wr_reg(6'h00, 32'h0);
        pin_chk(0, 1'b0, "R7 immediate");
        repeat (3) @(negedge clk);
        pin_chk(0, 1'b0, "R7 stays low");
    endtask

    task automatic t_update();
        bit bad = 1'b0;
        bit e;
        wr_reg(6'h30, 32'h0004_0004);
        wr_reg(6'h10, 32'h8000_0000);
        @(negedge clk);
        wr_reg(6'h30, 32'h0001_0002);
        grab(20);
        checks++;
        for (int i = 0; i < 20; i++) begin
            int k = i + 2;
            e = (k <= 8) ? ((k - 1) < 4) : (((k - 9) % 3) < 1);
            if (!bad && tr[i][4] !== e) begin
                bad = 1'b1;
                fails++;
                $display("FAIL R8 sample %0d actual=%b expected=%b", k, tr[i][4], e);
            end
        end
        all_off();
    endtask

    task automatic t_const();
        wr_reg(6'h34, 32'h0000_0005);
        wr_reg(6'h14, 32'h8000_0000);
        grab(12);
        cmp(5, 0, 12, 0, 0, 5, 0, "R9 zero high");
        wr_reg(6'h14, 32'h0);
        wr_reg(6'h34, 32'h0006_0000);
        wr_reg(6'h14, 32'h8000_0000);
        grab(15);
        cmp(5, 0, 15, 0, 6, 0, 0, "R9 zero low");
        all_off();
    endtask

    task automatic t_unmapped();
        wr_reg(6'h20, 32'h0003_0002);
        wr_reg(6'h18, 32'hFFFF_FFFF);
        wr_reg(6'h1C, 32'hFFFF_FFFF);
        wr_reg(6'h38, 32'hFFFF_FFFF);
        wr_reg(6'h3C, 32'hFFFF_FFFF);
        rd_chk(6'h18, 32'h0, "R10 read 18");
        rd_chk(6'h3C, 32'h0, "R10 read 3C");
        rd_chk(6'h20, 32'h0003_0002, "R10 neighbour");
        rd_chk(6'h00, 32'h0, "R10 ctrl0");
        repeat (2) @(negedge clk);
        checks++;
        if (pwm !== 6'h0) begin
            fails++;
            $display("FAIL R10 pins actual=%h expected=00", pwm);
        end
    endtask

    task automatic t_indep();
        wr_reg(6'h24, 32'h0001_0001);
        wr_reg(6'h28, 32'h0003_0001);
        wr_reg(6'h04, 32'h8000_0000);
        wr_reg(6'h08, 32'h8000_0000);
        grab(30);
        cmp(1, 1, 30, 0, 1, 1, 0, "R11 ch1");
        cmp(2, 0, 30, 0, 3, 1, 0, "R11 ch2");
        all_off();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_basic();
        t_lead();
        t_repeat();
        t_disable();
        t_update();
        t_const();
        t_unmapped();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule